// File: doc/BRIEF.md
# Drain-Before-Switch Memory Port Multiplexer

This block lets two client engines, numbered 0 and 1, take turns using one memory that has an independent read port and write port. Each port works as a request/response exchange, and every stream is a valid/ready handshake. One client owns the memory at any time. The block passes that client's read and write requests through to the memory and sends the memory's responses back to it. The other client is held off.

A separate select stream names the client that should own the memory next. The block polls this stream without blocking, so traffic keeps moving while no select value is offered. A select value that names the current owner is taken and nothing changes. A select value that names the other client starts a switch. From then on no new requests are taken from the current owner. Ownership moves in the first cycle in which neither port has a transaction outstanding. Each port keeps a count of its outstanding transactions. The count rises when the memory accepts a request and falls when a response is delivered to the client.

Top module: `mem_port_mux`

## Requirements
- R1: After reset, client 0 owns the memory, no switch is pending, both outstanding counts are zero and `sel_ready` is high.
- R2: The owner's read requests reach the memory with their address, with `req_ready` following the memory's ready. The memory's read responses reach the owner with their data, and `m_rd_rsp_ready` follows the owner's ready.
- R3: The owner's write requests reach the memory with their address and data. The memory's write responses reach the owner.
- R4: The client that does not own the memory sees `req_ready` low on both ports and `rsp_valid` low on both ports.
- R5: A select value equal to the current owner is consumed in one handshake. Ownership does not change, no drain is started, and `sel_ready` stays high.
- R6: After a select value naming the other client is accepted, a switch is pending. While it is pending, `sel_ready` is low, so any further select value is held off. The owner's requests on both ports are refused, and the memory sees no request valid.
- R7: A pending switch completes at the first clock edge at which both outstanding counts are zero. Ownership never changes while either count is nonzero. Responses therefore always return to the client that issued the request.
- R8: A port that has `MAX_OUT` transactions outstanding accepts no further request until a response is delivered.
- R9: When `sel_valid` is low, requests and responses flow without any stall caused by the select stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Select value offered |
| sel_ready | output | 1 | Select value taken (high unless a switch is pending) |
| sel_client | input | 1 | Client to own the memory next |
| c_rd_req_valid | input | 2 | Per-client read request valid |
| c_rd_req_ready | output | 2 | Per-client read request ready |
| c_rd_req_addr | input | 2×AW | Per-client read address |
| c_rd_rsp_valid | output | 2 | Per-client read response valid |
| c_rd_rsp_ready | input | 2 | Per-client read response ready |
| c_rd_rsp_data | output | DW | Read data (shared by both clients, qualified by valid) |
| c_wr_req_valid | input | 2 | Per-client write request valid |
| c_wr_req_ready | output | 2 | Per-client write request ready |
| c_wr_req_addr | input | 2×AW | Per-client write address |
| c_wr_req_data | input | 2×DW | Per-client write data |
| c_wr_rsp_valid | output | 2 | Per-client write response valid |
| c_wr_rsp_ready | input | 2 | Per-client write response ready |
| m_rd_req_valid | output | 1 | Read request to memory |
| m_rd_req_ready | input | 1 | Memory takes the read request |
| m_rd_req_addr | output | AW | Read address to memory |
| m_rd_rsp_valid | input | 1 | Read response from memory |
| m_rd_rsp_ready | output | 1 | Read response taken |
| m_rd_rsp_data | input | DW | Read data from memory |
| m_wr_req_valid | output | 1 | Write request to memory |
| m_wr_req_ready | input | 1 | Memory takes the write request |
| m_wr_req_addr | output | AW | Write address to memory |
| m_wr_req_data | output | DW | Write data to memory |
| m_wr_rsp_valid | input | 1 | Write response from memory |
| m_wr_rsp_ready | output | 1 | Write response taken |

## Verification
The assertions check the drain rule on every cycle. Ownership changes only after a pending switch, and only when both counts were zero. Ownership stays put while anything is outstanding. No request reaches the memory during a pending switch. The counts stay within `MAX_OUT`. The directed scenarios cover what a cycle-level property cannot show well. These are the forwarding of addresses and data and the return of responses to the issuing client. They also cover the silent consumption of a select value that names the current owner, the exact edge at which a switch lands, and the refusal of requests once a port is full.

// File: rtl/mem_mux_pkg.sv
package mem_mux_pkg;

    // Ownership controller state
    typedef struct packed {
        logic owner;   // client currently holding the memory
        logic pend;    // a switch has been requested and not yet done
        logic target;  // client that will own the memory after the switch
    } own_state_t;

    localparam own_state_t OWN_RESET = '{owner: 1'b0, pend: 1'b0, target: 1'b0};

endpackage

// File: rtl/mem_txn_counter.sv
module mem_txn_counter #(
    parameter int MAX_OUT = 4,
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          idle
);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_OUT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({inc, dec})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign full = (cnt_q == CNT_MAX);
    assign idle = (cnt_q == '0);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/mem_port_route.sv
module mem_port_route #(
    parameter int MAX_OUT = 4,
    localparam int CW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          owner,
    input  logic          grant,
    input  logic [1:0]    c_req_valid,
    output logic [1:0]    c_req_ready,
    output logic [1:0]    c_rsp_valid,
    input  logic [1:0]    c_rsp_ready,
    output logic          m_req_valid,
    input  logic          m_req_ready,
    input  logic          m_rsp_valid,
    output logic          m_rsp_ready,
    output logic [CW-1:0] cnt,
    output logic          idle
);
    logic full;
    logic open_q;
    logic req_fire, rsp_fire;

    // Requests pass only for the owner, when no switch pends and room is left
    assign open_q      = grant && !full;
    assign m_req_valid = c_req_valid[owner] && open_q;
    assign m_rsp_ready = c_rsp_ready[owner];

    for (genvar i = 0; i < 2; i++) begin : g_client
        assign c_req_ready[i] = (owner == 1'(i)) && open_q && m_req_ready;
        assign c_rsp_valid[i] = (owner == 1'(i)) && m_rsp_valid;
    end

    assign req_fire = m_req_valid && m_req_ready;
    assign rsp_fire = m_rsp_valid && m_rsp_ready;

    mem_txn_counter #(.MAX_OUT(MAX_OUT)) i_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (req_fire),
        .dec  (rsp_fire),
        .cnt  (cnt),
        .full (full),
        .idle (idle)
    );

endmodule

// File: rtl/mem_owner_ctrl.sv
module mem_owner_ctrl
    import mem_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_valid,
    output logic sel_ready,
    input  logic sel_client,
    input  logic rd_idle,
    input  logic wr_idle,
    output logic owner,
    output logic grant,
    output logic pend
);
    own_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            // Drained: hand over in this cycle
            if (rd_idle && wr_idle) begin
                st_d.owner = st_q.target;
                st_d.pend  = 1'b0;
            end
        end else if (sel_valid && sel_client != st_q.owner) begin
            st_d.pend   = 1'b1;
            st_d.target = sel_client;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OWN_RESET;
        else        st_q <= st_d;
    end

    assign sel_ready = !st_q.pend;
    assign grant     = !st_q.pend;
    assign owner     = st_q.owner;
    assign pend      = st_q.pend;

    // R7
    switch_when_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner != $past(st_q.owner)) |-> $past(rd_idle && wr_idle && st_q.pend));

endmodule

// File: rtl/mem_port_mux.sv
module mem_port_mux #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int MAX_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_valid,
    output logic               sel_ready,
    input  logic               sel_client,
    input  logic [1:0]         c_rd_req_valid,
    output logic [1:0]         c_rd_req_ready,
    input  logic [1:0][AW-1:0] c_rd_req_addr,
    output logic [1:0]         c_rd_rsp_valid,
    input  logic [1:0]         c_rd_rsp_ready,
    output logic [DW-1:0]      c_rd_rsp_data,
    input  logic [1:0]         c_wr_req_valid,
    output logic [1:0]         c_wr_req_ready,
    input  logic [1:0][AW-1:0] c_wr_req_addr,
    input  logic [1:0][DW-1:0] c_wr_req_data,
    output logic [1:0]         c_wr_rsp_valid,
    input  logic [1:0]         c_wr_rsp_ready,
    output logic               m_rd_req_valid,
    input  logic               m_rd_req_ready,
    output logic [AW-1:0]      m_rd_req_addr,
    input  logic               m_rd_rsp_valid,
    output logic               m_rd_rsp_ready,
    input  logic [DW-1:0]      m_rd_rsp_data,
    output logic               m_wr_req_valid,
    input  logic               m_wr_req_ready,
    output logic [AW-1:0]      m_wr_req_addr,
    output logic [DW-1:0]      m_wr_req_data,
    input  logic               m_wr_rsp_valid,
    output logic               m_wr_rsp_ready
);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic          owner, grant, pend;
    logic          rd_idle, wr_idle;
    logic [CW-1:0] rd_cnt, wr_cnt;

    mem_owner_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_valid (sel_valid),
        .sel_ready (sel_ready),
        .sel_client(sel_client),
        .rd_idle   (rd_idle),
        .wr_idle   (wr_idle),
        .owner     (owner),
        .grant     (grant),
        .pend      (pend)
    );

    mem_port_route #(.MAX_OUT(MAX_OUT)) i_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (owner),
        .grant      (grant),
        .c_req_valid(c_rd_req_valid),
        .c_req_ready(c_rd_req_ready),
        .c_rsp_valid(c_rd_rsp_valid),
        .c_rsp_ready(c_rd_rsp_ready),
        .m_req_valid(m_rd_req_valid),
        .m_req_ready(m_rd_req_ready),
        .m_rsp_valid(m_rd_rsp_valid),
        .m_rsp_ready(m_rd_rsp_ready),
        .cnt        (rd_cnt),
        .idle       (rd_idle)
    );

    mem_port_route #(.MAX_OUT(MAX_OUT)) i_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (owner),
        .grant      (grant),
        .c_req_valid(c_wr_req_valid),
        .c_req_ready(c_wr_req_ready),
        .c_rsp_valid(c_wr_rsp_valid),
        .c_rsp_ready(c_wr_rsp_ready),
        .m_req_valid(m_wr_req_valid),
        .m_req_ready(m_wr_req_ready),
        .m_rsp_valid(m_wr_rsp_valid),
        .m_rsp_ready(m_wr_rsp_ready),
        .cnt        (wr_cnt),
        .idle       (wr_idle)
    );

    // Payload steering by owner; response data is shared, qualified by valid
    assign m_rd_req_addr = c_rd_req_addr[owner];
    assign m_wr_req_addr = c_wr_req_addr[owner];
    assign m_wr_req_data = c_wr_req_data[owner];
    assign c_rd_rsp_data = m_rd_rsp_data;

    // R6
    no_req_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !((m_rd_req_valid && m_rd_req_ready) || (m_wr_req_valid && m_wr_req_ready)));

    // R7
    owner_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt != '0 || wr_cnt != '0) |=> $stable(owner));

    // R4
    idle_client_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(owner) |-> ((c_rd_rsp_valid | c_wr_rsp_valid) & ~(2'b01 << owner)) == 2'b00);

endmodule

// File: tb/test_mem_port_mux.sv
module test_mem_port_mux;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 8, MAX_OUT = 4;

    logic clk = 0, rst_n = 0;
    logic sel_valid = 0, sel_ready, sel_client = 0;
    logic [1:0] c_rd_req_valid = 0, c_rd_req_ready;
    logic [1:0][AW-1:0] c_rd_req_addr = '0;
    logic [1:0] c_rd_rsp_valid, c_rd_rsp_ready = 0;
    logic [DW-1:0] c_rd_rsp_data;
    logic [1:0] c_wr_req_valid = 0, c_wr_req_ready;
    logic [1:0][AW-1:0] c_wr_req_addr = '0;
    logic [1:0][DW-1:0] c_wr_req_data = '0;
    logic [1:0] c_wr_rsp_valid, c_wr_rsp_ready = 0;
    logic m_rd_req_valid, m_rd_req_ready = 0;
    logic [AW-1:0] m_rd_req_addr;
    logic m_rd_rsp_valid = 0, m_rd_rsp_ready;
    logic [DW-1:0] m_rd_rsp_data = '0;
    logic m_wr_req_valid, m_wr_req_ready = 0;
    logic [AW-1:0] m_wr_req_addr;
    logic [DW-1:0] m_wr_req_data;
    logic m_wr_rsp_valid = 0, m_wr_rsp_ready;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_port_mux #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT)) i_mem_port_mux (
        .clk(clk), .rst_n(rst_n),
        .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_client(sel_client),
        .c_rd_req_valid(c_rd_req_valid), .c_rd_req_ready(c_rd_req_ready),
        .c_rd_req_addr(c_rd_req_addr), .c_rd_rsp_valid(c_rd_rsp_valid),
        .c_rd_rsp_ready(c_rd_rsp_ready), .c_rd_rsp_data(c_rd_rsp_data),
        .c_wr_req_valid(c_wr_req_valid), .c_wr_req_ready(c_wr_req_ready),
        .c_wr_req_addr(c_wr_req_addr), .c_wr_req_data(c_wr_req_data),
        .c_wr_rsp_valid(c_wr_rsp_valid), .c_wr_rsp_ready(c_wr_rsp_ready),
        .m_rd_req_valid(m_rd_req_valid), .m_rd_req_ready(m_rd_req_ready),
        .m_rd_req_addr(m_rd_req_addr), .m_rd_rsp_valid(m_rd_rsp_valid),
        .m_rd_rsp_ready(m_rd_rsp_ready), .m_rd_rsp_data(m_rd_rsp_data),
        .m_wr_req_valid(m_wr_req_valid), .m_wr_req_ready(m_wr_req_ready),
        .m_wr_req_addr(m_wr_req_addr), .m_wr_req_data(m_wr_req_data),
        .m_wr_rsp_valid(m_wr_rsp_valid), .m_wr_rsp_ready(m_wr_rsp_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance one clock edge, land on the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        c_rd_req_valid = 2'b11; c_rd_req_addr = '{8'h21, 8'h10};
        c_wr_req_valid = 2'b11; m_rd_req_ready = 1; m_wr_req_ready = 1;
        settle();
        chk("R1 sel_ready", 32'(sel_ready), 1);
        chk("R1 rd ready owner0", 32'(c_rd_req_ready), 32'b01);
        chk("R1 rd addr", 32'(m_rd_req_addr), 32'h10);
        chk("R4 wr ready nonowner", 32'(c_wr_req_ready), 32'b01);
        c_rd_req_valid = 0; c_wr_req_valid = 0;
    endtask

    task automatic t_read();
        // sel_valid stays low throughout: R9
        c_rd_req_valid = 2'b11; c_rd_req_addr = '{8'h77, 8'h12};
        settle();
        chk("R2 m_rd_req_valid", 32'(m_rd_req_valid), 1);
        chk("R2 m_rd_req_addr", 32'(m_rd_req_addr), 32'h12);
        step();
        c_rd_req_valid = 0;
        m_rd_rsp_valid = 1; m_rd_rsp_data = 8'hAB; c_rd_rsp_ready = 2'b11;
        settle();
        chk("R2 rsp to owner", 32'(c_rd_rsp_valid), 32'b01);
        chk("R2 rsp data", 32'(c_rd_rsp_data), 32'hAB);
        chk("R9 m_rd_rsp_ready", 32'(m_rd_rsp_ready), 1);
        step();
        m_rd_rsp_valid = 0;
    endtask

    task automatic t_write();
        c_wr_req_valid = 2'b01; c_wr_req_addr = '{8'h00, 8'h44};
        c_wr_req_data = '{8'h00, 8'h99};
        settle();
        chk("R3 m_wr_req_valid", 32'(m_wr_req_valid), 1);
        chk("R3 m_wr_req_addr", 32'(m_wr_req_addr), 32'h44);
        chk("R3 m_wr_req_data", 32'(m_wr_req_data), 32'h99);
        step();
        c_wr_req_valid = 0;
        m_wr_rsp_valid = 1; c_wr_rsp_ready = 2'b11;
        settle();
        chk("R3 wr rsp to owner", 32'(c_wr_rsp_valid), 32'b01);
        chk("R3 m_wr_rsp_ready", 32'(m_wr_rsp_ready), 1);
        step();
        m_wr_rsp_valid = 0;
    endtask

    task automatic t_same_sel();
        sel_valid = 1; sel_client = 0;
        settle();
        chk("R5 sel taken", 32'(sel_ready), 1);
        step();
        sel_valid = 0;
        c_rd_req_valid = 2'b11; c_rd_req_addr = '{8'h01, 8'h02};
        settle();
        chk("R5 no drain sel_ready", 32'(sel_ready), 1);
        chk("R5 owner kept", 32'(c_rd_req_ready), 32'b01);
        c_rd_req_valid = 0;
    endtask

    task automatic t_switch();
        c_rd_req_valid = 2'b01; c_rd_req_addr = '{8'h31, 8'h30};
        step();                               // one read outstanding for client 0
        c_rd_req_valid = 0;
        sel_valid = 1; sel_client = 1;
        settle();
        chk("R6 sel accepted", 32'(sel_ready), 1);
        step();                               // switch now pending
        sel_valid = 1; sel_client = 0;        // second select held off
        c_rd_req_valid = 2'b11; c_wr_req_valid = 2'b11;
        settle();
        chk("R6 sel held", 32'(sel_ready), 0);
        chk("R6 rd refused", 32'(c_rd_req_ready), 32'b00);
        chk("R6 wr refused", 32'(c_wr_req_ready), 32'b00);
        chk("R6 no mem req", 32'(m_rd_req_valid), 0);
        step();
        sel_valid = 0;
        c_wr_req_valid = 0;
        m_rd_rsp_valid = 1; m_rd_rsp_data = 8'h5A; c_rd_rsp_ready = 2'b11;
        settle();
        chk("R7 rsp to issuer", 32'(c_rd_rsp_valid), 32'b01);
        step();                               // count back to zero
        m_rd_rsp_valid = 0;
        settle();
        chk("R7 not yet switched", 32'(c_rd_req_ready), 32'b00);
        step();                               // handover edge
        settle();
        chk("R7 client1 owns", 32'(c_rd_req_ready), 32'b10);
        chk("R7 client1 addr", 32'(m_rd_req_addr), 32'h31);
        chk("R7 sel free", 32'(sel_ready), 1);
        c_rd_req_valid = 0;
    endtask

    task automatic t_cap();
        c_rd_req_valid = 2'b10;
        for (int k = 0; k < MAX_OUT; k++) step();
        settle();
        chk("R8 full refuses", 32'(c_rd_req_ready), 32'b00);
        chk("R8 no mem req", 32'(m_rd_req_valid), 0);
        c_rd_req_valid = 0;
        m_rd_rsp_valid = 1; c_rd_rsp_ready = 2'b11;
        for (int k = 0; k < MAX_OUT; k++) begin
            settle();
            chk("R4 rsp to client1", 32'(c_rd_rsp_valid), 32'b10);
            step();
        end
        m_rd_rsp_valid = 0;
        c_rd_req_valid = 2'b10;
        settle();
        chk("R8 room again", 32'(c_rd_req_ready), 32'b10);
        c_rd_req_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_same_sel();
        t_switch();
        t_cap();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule